// File: doc/BRIEF.md
# Floating-Point Compare and Status Unit

This block compares two single-precision IEEE 754 values and reports how they relate as a four-bit condition code (negative, zero, carry, overflow) held in a 32-bit status and control register. A one-cycle start strobe launches a compare. One cycle later a done pulse appears, and the register shows the new condition code and any new sticky exceptions.

The same register holds two mode bits. The flush bit makes subnormal inputs count as signed zero. The default-NaN bit is stored for the arithmetic units that share the register and has no effect on a compare. Two sticky bits record an invalid compare and a subnormal input that was flushed. Software reads the register at all times and can write it. Writing 0 to a sticky bit clears it.

Field positions in the 32-bit register: condition code N/Z/C/V at bits 31/30/29/28, default-NaN enable at bit 25, flush enable at bit 24, subnormal-input sticky at bit 7, invalid-operation sticky at bit 0. All other bits read as 0.

Top module: `fcmp_status_unit`

## Requirements
- R1: When the operands are equal, bits 31:28 become 0110 (N=0, Z=1, C=1, V=0).
- R2: When operand A is less than operand B, bits 31:28 become 1000.
- R3: When A is greater than B, bits 31:28 become 0010. Infinities order above or below every finite value according to their sign.
- R4: When either operand is a NaN (exponent all ones, fraction non-zero), the result is unordered and bits 31:28 become 0011.
- R5: Positive zero and negative zero compare as equal.
- R6: With bit 24 set, a subnormal operand is compared as a zero that keeps its sign. With bit 24 clear, subnormals are compared exactly by value.
- R7: Bit 0 is set when either operand is a signalling NaN (fraction bit 22 clear). A quiet NaN (fraction bit 22 set) sets bit 0 only when sig_cmp is high during start. Once set, bit 0 stays set until it is written to 0.
- R8: Bit 7 is set only when a compare runs with bit 24 set and at least one operand is subnormal. Once set, it stays set until it is written to 0.
- R9: done is high exactly in the cycle after a start cycle. The condition code and sticky bits change in that same cycle. Without a start or a write, the condition code holds.
- R10: A write loads bits 31:28, 25, 24, 7 and 0 from wr_data, and every other bit reads 0. If a write that clears a sticky bit coincides with a compare that raises the same exception, the bit ends up set. If a write coincides with a compare, the compare's condition code wins.
- R11: Bit 25 is stored and read back, and it does not change any compare result.
- R12: After reset, the register reads 0 and done is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Starts a compare of op_a with op_b |
| sig_cmp | input | 1 | Selects the signalling compare, in which a quiet NaN is also invalid |
| op_a | input | 32 | First operand, single precision |
| op_b | input | 32 | Second operand, single precision |
| wr_en | input | 1 | Writes wr_data into the register |
| wr_data | input | 32 | Value to write |
| done | output | 1 | Pulses one cycle after start |
| csr_rdata | output | 32 | Current register contents |

## Verification
The bench goes after signed zeros, subnormals with flush on and with flush off, infinities against the largest finite value, quiet and signalling NaNs with and without sig_cmp, and a clearing write that lands in the same cycle as a new exception. Each case has a typical failure. A design that compares raw bit patterns reports +0 and -0 as unequal and gets the order of negative numbers backwards. A design that ignores the flush bit reports a subnormal compared with zero as greater. A design that lets the write win the conflict loses an exception. A design that flags every NaN as invalid sets bit 0 on a quiet NaN. Every cycle is checked against a behavioural model that compares signed integer magnitudes, so any difference in the condition code, the sticky bits or the timing of done shows up.

// File: rtl/fcmp_pkg.sv
// Package: shared types, register field positions and the condition-code
// encoding for the compare unit. Assumes a 32-bit status register.
package fcmp_pkg;

    localparam int CSR_W   = 32;
    localparam int POS_N   = 31;
    localparam int POS_V   = 28;
    localparam int POS_DN  = 25;
    localparam int POS_FZ  = 24;
    localparam int POS_IDE = 7;
    localparam int POS_IOC = 0;

    // Classification of one operand after the flush decision
    typedef struct packed {
        logic is_zero;    // zero, or a subnormal that was flushed
        logic is_denorm;  // raw operand is subnormal
        logic is_nan;
        logic is_snan;
    } opclass_t;

    typedef enum logic [1:0] {
        REL_EQ = 2'd0,
        REL_LT = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } relation_e;

    // Maps a relation to its N,Z,C,V code
    function automatic logic [3:0] rel_to_nzcv(relation_e r);
        case (r)
            REL_EQ:  return 4'b0110;
            REL_LT:  return 4'b1000;
            REL_GT:  return 4'b0010;
            default: return 4'b0011;
        endcase
    endfunction

endpackage

// File: rtl/fcmp_classify.sv
// Operand classifier: works out zero, subnormal, NaN and signalling NaN, and
// produces the operand as it will be compared (a flushed subnormal becomes a
// zero that keeps its sign). Assumes IEEE-style layout {sign, exp, frac}.
module fcmp_classify
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] op,
    input  logic         flush,
    output opclass_t     cls,
    output logic [W-1:0] eff_op
);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_zero, exp_ones, frac_zero;

    assign exp_f     = op[W-2 -: EXP_W];
    assign frac_f    = op[FRAC_W-1:0];
    assign exp_zero  = (exp_f == '0);
    assign exp_ones  = (exp_f == '1);
    assign frac_zero = (frac_f == '0);

    // Classify the operand and apply the flush decision
    always_comb begin
        cls.is_denorm = exp_zero && !frac_zero;
        cls.is_nan    = exp_ones && !frac_zero;
        cls.is_snan   = cls.is_nan && !frac_f[FRAC_W-1];
        cls.is_zero   = exp_zero && (frac_zero || flush);
        eff_op        = (cls.is_denorm && flush) ? {op[W-1], {(W-1){1'b0}}} : op;
    end

endmodule

// File: rtl/fcmp_order.sv
// Ordering decision: maps each operand to an unsigned key whose order
// matches the numeric order, then compares the keys. NaNs give unordered and
// two zeros of any sign give equal. Assumes the operands were already flushed.
module fcmp_order
    import fcmp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  opclass_t     cls_a,
    input  opclass_t     cls_b,
    output relation_e    rel
);

    logic [W-1:0] key_a, key_b;

    // Negative values are inverted; positive ones get their top bit set
    always_comb begin
        key_a = a[W-1] ? ~a : (a | {1'b1, {(W-1){1'b0}}});
        key_b = b[W-1] ? ~b : (b | {1'b1, {(W-1){1'b0}}});
    end

    // Choose the relation, with the special cases taking priority
    always_comb begin
        if (cls_a.is_nan || cls_b.is_nan)       rel = REL_UN;
        else if (cls_a.is_zero && cls_b.is_zero) rel = REL_EQ;
        else if (key_a == key_b)                 rel = REL_EQ;
        else if (key_a < key_b)                  rel = REL_LT;
        else                                     rel = REL_GT;
    end

endmodule

// File: rtl/fcmp_csr.sv
// Status and control register: condition code, mode bits and sticky
// exception bits. On a start cycle the compare result wins over a
// simultaneous write of the code, and a new exception wins over a clear.
module fcmp_csr
    import fcmp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    input  logic             upd,
    input  relation_e        rel,
    input  logic             exc_inv,
    input  logic             exc_den,
    output logic             flush_en,
    output logic [CSR_W-1:0] rdata
);

    logic [3:0] nzcv_q;
    logic       dn_q, fz_q, ide_q, ioc_q;
    logic       unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[27:26], wr_data[23:8], wr_data[6:1]};

    // Register update: write first, then the compare result on top
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nzcv_q <= '0;
            dn_q   <= 1'b0;
            fz_q   <= 1'b0;
            ide_q  <= 1'b0;
            ioc_q  <= 1'b0;
        end else begin
            if (wr_en) begin
                nzcv_q <= wr_data[POS_N:POS_V];
                dn_q   <= wr_data[POS_DN];
                fz_q   <= wr_data[POS_FZ];
                ide_q  <= wr_data[POS_IDE] | (upd & exc_den);
                ioc_q  <= wr_data[POS_IOC] | (upd & exc_inv);
            end else begin
                ide_q  <= ide_q | (upd & exc_den);
                ioc_q  <= ioc_q | (upd & exc_inv);
            end
            if (upd) nzcv_q <= rel_to_nzcv(rel);
        end
    end

    // Assemble the read view; undefined bits read as zero
    always_comb begin
        rdata           = '0;
        rdata[POS_N:POS_V] = nzcv_q;
        rdata[POS_DN]   = dn_q;
        rdata[POS_FZ]   = fz_q;
        rdata[POS_IDE]  = ide_q;
        rdata[POS_IOC]  = ioc_q;
    end

    assign flush_en = fz_q;

endmodule

// File: rtl/fcmp_status_unit.sv
// Top: single-precision compare with status register. A start strobe
// compares op_a with op_b under the current flush mode; done and the updated
// register appear in the next cycle. Assumes start lasts one cycle per compare.
module fcmp_status_unit
    import fcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             sig_cmp,
    input  logic [W-1:0]     op_a,
    input  logic [W-1:0]     op_b,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    output logic             done,
    output logic [CSR_W-1:0] csr_rdata
);

    logic [W-1:0] ops     [2];
    logic [W-1:0] eff_ops [2];
    opclass_t     cls     [2];
    logic         flush_en;
    relation_e    rel;
    logic         exc_inv, exc_den;

    assign ops[0] = op_a;
    assign ops[1] = op_b;

    for (genvar g = 0; g < 2; g++) begin : g_cls
        fcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) i_cls (
            .op     (ops[g]),
            .flush  (flush_en),
            .cls    (cls[g]),
            .eff_op (eff_ops[g])
        );
    end

    fcmp_order #(.W(W)) i_order (
        .a     (eff_ops[0]),
        .b     (eff_ops[1]),
        .cls_a (cls[0]),
        .cls_b (cls[1]),
        .rel   (rel)
    );

    // Exceptions raised by this compare
    always_comb begin
        exc_inv = cls[0].is_snan || cls[1].is_snan ||
                  (sig_cmp && (cls[0].is_nan || cls[1].is_nan));
        exc_den = flush_en && (cls[0].is_denorm || cls[1].is_denorm);
    end

    fcmp_csr i_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .upd      (start),
        .rel      (rel),
        .exc_inv  (exc_inv),
        .exc_den  (exc_den),
        .flush_en (flush_en),
        .rdata    (csr_rdata)
    );

    // Done pulse one cycle after start
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= start;
    end

endmodule

// File: rtl/fcmp_status_unit_chk.sv
// Checker: temporal properties of the compare unit, bound to the top.
module fcmp_status_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        wr_en,
    input logic        done,
    input logic [31:0] csr_rdata
);

    AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done); // R9

    AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start)); // R9

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !$past(wr_en)) |->
        (csr_rdata[31:28] == 4'b0110 || csr_rdata[31:28] == 4'b1000 ||
         csr_rdata[31:28] == 4'b0010 || csr_rdata[31:28] == 4'b0011)); // R1

    AST_CODE_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(start) && !$past(wr_en)) |-> $stable(csr_rdata[31:28])); // R9

    AST_INVALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(csr_rdata[0]) && !$past(wr_en)) |-> csr_rdata[0]); // R7

    AST_DENORM_NEEDS_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(csr_rdata[7]) && !$past(wr_en)) |-> $past(csr_rdata[24])); // R8

endmodule

bind fcmp_status_unit fcmp_status_unit_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .wr_en     (wr_en),
    .done      (done),
    .csr_rdata (csr_rdata)
);

// File: tb/test_fcmp_status_unit.sv
`timescale 1ns/1ps
module test_fcmp_status_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, sig_cmp = 1'b0, wr_en = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, wr_data = '0;
    logic        done;
    logic [31:0] csr_rdata;

    int vectors = 0, miscompares = 0, cyc = 0;

    // Behavioural model state
    logic [3:0] m_code = '0;
    logic       m_dn = 0, m_fz = 0, m_ide = 0, m_ioc = 0, m_done = 0;

    always #2.5 clk = ~clk;

    fcmp_status_unit i_fcmp_status_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .sig_cmp(sig_cmp),
        .op_a(op_a), .op_b(op_b), .wr_en(wr_en), .wr_data(wr_data),
        .done(done), .csr_rdata(csr_rdata)
    );

    function automatic logic [31:0] m_view();
        return {m_code, 2'b00, m_dn, m_fz, 16'h0, m_ide, 6'h0, m_ioc};
    endfunction

    function automatic bit is_nan(logic [31:0] x);
        return x[30:23] == 8'hFF && x[22:0] != 0;
    endfunction

    function automatic bit is_sub(logic [31:0] x);
        return x[30:23] == 8'h00 && x[22:0] != 0;
    endfunction

    // Signed value as an integer; ordering of finite and infinite floats
    function automatic longint val(logic [31:0] x, bit fz);
        longint mag = (fz && x[30:23] == 0) ? 0 : longint'(x[30:0]);
        return x[31] ? -mag : mag;
    endfunction

    function automatic logic [3:0] ref_code(logic [31:0] a, logic [31:0] b, bit fz);
        if (is_nan(a) || is_nan(b)) return 4'b0011;
        if (val(a, fz) == val(b, fz)) return 4'b0110;
        if (val(a, fz) <  val(b, fz)) return 4'b1000;
        return 4'b0010;
    endfunction

    task automatic check(string tag);
        vectors++;
        if (done !== m_done || csr_rdata !== m_view()) begin
            miscompares++;
            $display("FAIL %s actual done=%0b reg=%08h expected done=%0b reg=%08h",
                     tag, done, csr_rdata, m_done, m_view());
        end
    endtask

    // One clock: drive at negedge, update model at posedge, compare at next negedge
    task automatic step(logic st, logic sc, logic [31:0] a, logic [31:0] b,
                        logic we, logic [31:0] wd, string tag);
        logic [3:0] c;
        bit ei, ed;
        start = st; sig_cmp = sc; op_a = a; op_b = b; wr_en = we; wr_data = wd;
        @(posedge clk);
        c  = ref_code(a, b, m_fz);
        ei = st && ((is_nan(a) && !a[22]) || (is_nan(b) && !b[22]) ||
                    (sc && (is_nan(a) || is_nan(b))));
        ed = st && m_fz && (is_sub(a) || is_sub(b));
        if (we) begin
            m_code = wd[31:28]; m_dn = wd[25]; m_fz = wd[24];
            m_ide = wd[7] | ed;  m_ioc = wd[0] | ei;
        end else begin
            m_ide = m_ide | ed;  m_ioc = m_ioc | ei;
        end
        if (st) m_code = c;
        m_done = st;
        @(negedge clk);
        start = 0; wr_en = 0;
        check(tag);
    endtask

    task automatic cmp(logic [31:0] a, logic [31:0] b, string tag);
        step(1, 0, a, b, 0, 0, tag);
    endtask

    function automatic logic [31:0] pick();
        case ($urandom_range(0, 9))
            0: return {1'($urandom), 31'h0};
            1: return {1'($urandom), 8'h00, 23'($urandom)};
            2: return {1'($urandom), 8'hFF, 23'h0};
            3: return {1'($urandom), 8'hFF, 23'($urandom) | 23'h1};
            4: return 32'h3F800000;
            default: return $urandom;
        endcase
    endfunction

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            miscompares++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R12 reset");
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, "R12 idle after reset");

        cmp(32'h3F800000, 32'h3F800000, "R1 equal");
        cmp(32'h3F800000, 32'h40000000, "R2 less");
        cmp(32'hC0000000, 32'hBF800000, "R2 negative less");
        cmp(32'h40000000, 32'h3F800000, "R3 greater");
        cmp(32'h00000001, 32'hBF800000, "R3 positive over negative");
        cmp(32'h7F800000, 32'h7F7FFFFF, "R3 +inf over max");
        cmp(32'hFF800000, 32'hFF7FFFFF, "R2 -inf under -max");
        step(0, 0, 0, 0, 0, 0, "R9 done drops, code holds");
        cmp(32'h00000000, 32'h80000000, "R5 signed zeros equal");
        cmp(32'h7FC00000, 32'h3F800000, "R4 quiet NaN unordered, R7 no invalid");
        cmp(32'h3F800000, 32'h7F800001, "R7 signalling NaN invalid");
        cmp(32'h3F800000, 32'h3F800000, "R7 invalid sticks");
        step(0, 0, 0, 0, 1, 32'h0, "R10 write clears sticky");
        step(1, 1, 32'hFFC00001, 32'h0, 0, 0, "R7 signalling compare on quiet NaN");
        step(0, 0, 0, 0, 1, 32'h0, "R10 clear again");
        cmp(32'h00000001, 32'h00000002, "R6 exact subnormals less, R8 no flag");
        cmp(32'h00000001, 32'h00000000, "R6 exact subnormal greater than zero");
        step(0, 0, 0, 0, 1, 32'h03000000, "R10 R11 set mode bits");
        cmp(32'h00000001, 32'h00000002, "R6 flushed subnormals equal, R8 flag");
        cmp(32'h80000001, 32'h00000000, "R6 flushed negative subnormal equals zero");
        cmp(32'h00000005, 32'h00800000, "R6 flushed subnormal below min normal");
        step(1, 0, 32'h00000003, 32'h0, 1, 32'h01000000, "R10 new exception beats clear");
        step(1, 0, 32'h3F800000, 32'h40000000, 1, 32'h01000000, "R10 compare code beats write");
        step(0, 0, 0, 0, 1, 32'hFFFFFFFF, "R10 undefined bits read zero");
        cmp(32'h3F800000, 32'h3F800000, "R11 default-NaN bit no effect");
        step(0, 0, 0, 0, 1, 32'h00000000, "R10 clear all");

        for (int i = 0; i < 400; i++) begin
            if (i % 50 == 0)
                step(0, 0, 0, 0, 1, {7'h0, 1'($urandom), 24'h0}, "R10 random mode");
            step(1, 1'($urandom), pick(), pick(), 0, 0, "R1 R2 R3 R4 R6 R7 R8 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule